// File: doc/BRIEF.md
# Power Area Sequencing Controller

This block sequences power transitions for a set of power areas. The areas are split into groups, and each area owns one channel bit in its group's register window. Software asks for a power-down or a power-up by writing a one-hot channel word to the shutoff or resume command register of that group. The controller handles one transition at a time. It models the settling time of the power switch with a cycle count that software can program. When the count runs out, the area's power status bit changes.

While a transition runs, the two ready flags in the global status word read zero. A well-formed command that arrives during that time is refused. The refusal sets the channel's bit in the group's error register, and software retries until that bit reads clear.

When an area finishes its transition, the controller can record this in a per-area completion flag. The flag is set only if the area's enable bit is set. Software clears a flag by writing a one to its position in a clear register. A separate mask keeps an enabled flag from reaching the interrupt line, but the flag is still recorded.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the global status word at 0x00 reads 0x3. Completion flags (0x04), enables (0x0C) and masks (0x10) read zero, the settle count at 0x14 reads 4, every error word reads zero and irq is low. The power status word (group offset 0x00) reads 0x0 for group 0 at 0x40 and 0xF for group 1 at 0x60, where a one means the area is off.
- R2: Bit 0 of the global status word means ready for shutoff and bit 1 means ready for resume. Both bits read zero for as long as a transition is in progress, and both return to one once it ends.
- R3: When idle, a write of a one-hot channel word to group offset 0x04 starts a power-down of that channel's area, and a write to offset 0x0C starts a power-up. When the transition completes, the area's power status bit becomes 1 for a power-down and 0 for a power-up.
- R4: Once a command is accepted, the controller stays busy for exactly the settle count held at 0x14 (low 8 bits, writable). A settle count of zero acts as one cycle. The count is captured when the command is accepted.
- R5: A well-formed command written while busy sets the channel's bit in the group error word (offset 0x14) and leaves every power status bit unchanged.
- R6: A later accepted command for the same channel clears that channel's error bit.
- R7: A command word that is not one-hot within the group's channel bits is ignored: it causes no transition and no error.
- R8: A completing area sets completion flag bit group*4+channel, but only if the enable bit at that position in 0x0C is set.
- R9: Writing ones to 0x08 clears the corresponding completion flags. Writes to 0x04 have no effect.
- R10: irq is the OR of all completion flags whose enable bit is set and whose mask bit (0x10) is clear. Masking does not stop a flag from being recorded.
- R11: While a power-down is running, group offset 0x08 shows the active channel's bit. While a power-up is running, group offset 0x10 shows it. Both read zero when the controller is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | Completion interrupt |

## Verification
The bench drives power-down and power-up commands on areas in both groups, with settle counts of 4, 10 and 0. The different counts separate a correct busy window from an off-by-one or from a zero count that never ends. A command issued in the middle of a long transition shows whether it is refused, leaves power state untouched and is accepted on retry. Non-one-hot and out-of-range command words show whether malformed commands are filtered out. Completions run with the enable bit both set and cleared, and with the mask applied, which separates recording a flag from raising the interrupt.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int N_GROUPS     = 2,
  parameter int CH_PER_GROUP = 4,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int SETTLE_W     = 8,
  parameter int DEF_SETTLE   = 4,
  parameter int INIT_OFF     = 'hF0,
  parameter int GRP_BASE     = 'h40,
  parameter int GRP_STRIDE   = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int N       = N_GROUPS * CH_PER_GROUP;
  localparam int AREA_W  = (N > 1) ? $clog2(N) : 1;
  localparam int GRP_END = GRP_BASE + N_GROUPS * GRP_STRIDE;

  localparam int G_SR     = 'h00;
  localparam int G_ISR    = 'h04;
  localparam int G_ICLR   = 'h08;
  localparam int G_IEN    = 'h0C;
  localparam int G_IMSK   = 'h10;
  localparam int G_SETTLE = 'h14;

  localparam int P_STAT = 'h00;
  localparam int P_OFFC = 'h04;
  localparam int P_OFFS = 'h08;
  localparam int P_ONC  = 'h0C;
  localparam int P_ONS  = 'h10;
  localparam int P_ERR  = 'h14;

  logic [N-1:0]        pwr_off, isr, ier, imr, err;
  logic [SETTLE_W-1:0] settle, cnt;
  logic                busy, cur_off;
  logic [AREA_W-1:0]   cur_area;

  int                  addr_i, grp_i, off_i, ch_i;
  logic                in_grp, is_oh, req_valid, req_off;
  logic [AREA_W-1:0]   req_area;
  logic                accept, reject, done, clr_wr;
  logic [N-1:0]        cur_bit, off_act, on_act, set_bits, clr_bits;

  always_comb begin
    addr_i = int'(bus_addr);
    in_grp = (addr_i >= GRP_BASE) && (addr_i < GRP_END);
    grp_i  = in_grp ? (addr_i - GRP_BASE) / GRP_STRIDE : 0;
    off_i  = in_grp ? (addr_i - GRP_BASE) % GRP_STRIDE : 0;
    is_oh  = (bus_wdata != '0)
          && ((bus_wdata & (bus_wdata - DATA_W'(1))) == '0)
          && ((bus_wdata >> CH_PER_GROUP) == '0);
    ch_i = 0;
    for (int c = 0; c < CH_PER_GROUP; c++)
      if (bus_wdata[c]) ch_i = c;
    req_off   = (off_i == P_OFFC);
    req_valid = bus_we && in_grp && is_oh && ((off_i == P_OFFC) || (off_i == P_ONC));
    req_area  = AREA_W'(grp_i * CH_PER_GROUP + ch_i);
  end

  assign accept   = req_valid && !busy;
  assign reject   = req_valid && busy;
  assign done     = busy && (cnt == SETTLE_W'(1));
  assign cur_bit  = N'(1) << cur_area;
  assign off_act  = (busy && cur_off)  ? cur_bit : '0;
  assign on_act   = (busy && !cur_off) ? cur_bit : '0;
  assign set_bits = (done && ier[cur_area]) ? cur_bit : '0;
  assign clr_wr   = bus_we && !in_grp && (addr_i == G_ICLR);
  assign clr_bits = clr_wr ? bus_wdata[N-1:0] : '0;
  assign irq      = |(isr & ier & ~imr);

  always_comb begin
    bus_rdata = '0;
    if (in_grp) begin
      case (off_i)
        P_STAT:  bus_rdata[CH_PER_GROUP-1:0] = pwr_off[grp_i*CH_PER_GROUP +: CH_PER_GROUP];
        P_OFFS:  bus_rdata[CH_PER_GROUP-1:0] = off_act[grp_i*CH_PER_GROUP +: CH_PER_GROUP];
        P_ONS:   bus_rdata[CH_PER_GROUP-1:0] = on_act[grp_i*CH_PER_GROUP +: CH_PER_GROUP];
        P_ERR:   bus_rdata[CH_PER_GROUP-1:0] = err[grp_i*CH_PER_GROUP +: CH_PER_GROUP];
        default: ;
      endcase
    end else begin
      case (addr_i)
        G_SR:     bus_rdata[1:0]          = {!busy, !busy};
        G_ISR:    bus_rdata[N-1:0]        = isr;
        G_IEN:    bus_rdata[N-1:0]        = ier;
        G_IMSK:   bus_rdata[N-1:0]        = imr;
        G_SETTLE: bus_rdata[SETTLE_W-1:0] = settle;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_off  <= N'(INIT_OFF);
      isr      <= '0;
      ier      <= '0;
      imr      <= '0;
      err      <= '0;
      settle   <= SETTLE_W'(DEF_SETTLE);
      cnt      <= '0;
      busy     <= 1'b0;
      cur_off  <= 1'b0;
      cur_area <= '0;
    end else begin
      isr <= (isr & ~clr_bits) | set_bits;
      if (bus_we && !in_grp) begin
        case (addr_i)
          G_IEN:    ier    <= bus_wdata[N-1:0];
          G_IMSK:   imr    <= bus_wdata[N-1:0];
          G_SETTLE: settle <= bus_wdata[SETTLE_W-1:0];
          default: ;
        endcase
      end
      if (accept) begin
        busy          <= 1'b1;
        cnt           <= (settle == '0) ? SETTLE_W'(1) : settle;
        cur_area      <= req_area;
        cur_off       <= req_off;
        err[req_area] <= 1'b0;
      end
      if (reject) err[req_area] <= 1'b1;
      if (busy) begin
        if (done) begin
          busy              <= 1'b0;
          pwr_off[cur_area] <= cur_off;
        end else begin
          cnt <= cnt - SETTLE_W'(1);
        end
      end
    end
  end

  a_r3_idle_pwr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(pwr_off));

  a_r8_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isr & ~$past(isr) & ~$past(ier)) == '0));

  a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (isr != '0));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clr_wr) |=> $stable(isr));

  a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0));

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  int m_pwr, m_isr, m_ier, m_imr, m_err, m_settle, m_busy, m_left, m_area, m_off;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pwr = 'hF0; m_isr = 0; m_ier = 0; m_imr = 0; m_err = 0;
      m_settle = 4; m_busy = 0; m_left = 0; m_area = 0; m_off = 0;
    end else begin
      int a, wd, was_busy, fin, ch;
      a = int'(bus_addr);
      wd = int'(bus_wdata);
      was_busy = m_busy;
      fin = (m_busy != 0) && (m_left == 1);
      if (bus_we && a == 'h08) m_isr = m_isr & ~(wd & 'hFF);
      if (fin && ((m_ier >> m_area) & 1)) m_isr = m_isr | (1 << m_area);
      if (bus_we && a == 'h0C) m_ier = wd & 'hFF;
      if (bus_we && a == 'h10) m_imr = wd & 'hFF;
      if (bus_we && a == 'h14) m_settle = wd & 'hFF;
      ch = -1;
      if (wd == 1) ch = 0;
      if (wd == 2) ch = 1;
      if (wd == 4) ch = 2;
      if (wd == 8) ch = 3;
      if (bus_we && ch >= 0 && (a == 'h44 || a == 'h4C || a == 'h64 || a == 'h6C)) begin
        int idx;
        idx = ((a >= 'h60) ? 4 : 0) + ch;
        if (was_busy != 0) m_err = m_err | (1 << idx);
        else begin
          m_err = m_err & ~(1 << idx);
          m_busy = 1;
          m_left = (m_settle == 0) ? 1 : m_settle;
          m_area = idx;
          m_off = (a == 'h44 || a == 'h64) ? 1 : 0;
        end
      end
      if (was_busy != 0) begin
        if (fin) begin
          m_busy = 0;
          if (m_off != 0) m_pwr = m_pwr | (1 << m_area);
          else m_pwr = m_pwr & ~(1 << m_area);
        end else m_left = m_left - 1;
      end
    end
  end

  function automatic int mrd(int a);
    int g, o, act;
    if (a >= 'h40 && a < 'h80) begin
      g = (a - 'h40) / 'h20;
      o = (a - 'h40) % 'h20;
      act = (m_busy != 0) ? (1 << m_area) : 0;
      case (o)
        'h00: return (m_pwr >> (4*g)) & 'hF;
        'h08: return ((m_off != 0) ? act : 0) >> (4*g) & 'hF;
        'h10: return ((m_off == 0) ? act : 0) >> (4*g) & 'hF;
        'h14: return (m_err >> (4*g)) & 'hF;
        default: return 0;
      endcase
    end
    case (a)
      'h00: return (m_busy != 0) ? 0 : 3;
      'h04: return m_isr;
      'h0C: return m_ier;
      'h10: return m_imr;
      'h14: return m_settle;
      default: return 0;
    endcase
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      int exp_irq;
      exp_irq = ((m_isr & m_ier & ~m_imr) != 0) ? 1 : 0;
      checks++;
      if (int'(bus_rdata) != mrd(int'(bus_addr))) begin
        failures++;
        $display("FAIL R3 model read addr=%h actual=%h expected=%h", bus_addr, bus_rdata, mrd(int'(bus_addr)));
      end
      checks++;
      if (int'(irq) != exp_irq) begin
        failures++;
        $display("FAIL R10 model irq actual=%0d expected=%0d", irq, exp_irq);
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_we = 1'b1;
    bus_addr = 8'(a);
    bus_wdata = 32'(d);
    @(negedge clk);
    bus_we = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(int a, output int d);
    bus_addr = 8'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic wait_idle(output int n);
    int v;
    n = 0;
    rd('h00, v);
    while (v != 3) begin
      n++;
      @(negedge clk);
      rd('h00, v);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      summary();
    end
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd('h00, v); chk("R1 status", v, 3);
    rd('h04, v); chk("R1 flags", v, 0);
    rd('h0C, v); chk("R1 enables", v, 0);
    rd('h10, v); chk("R1 masks", v, 0);
    rd('h14, v); chk("R1 settle", v, 4);
    rd('h40, v); chk("R1 group0 power", v, 0);
    rd('h60, v); chk("R1 group1 power", v, 'hF);
    rd('h74, v); chk("R1 group1 error", v, 0);
    chk("R1 irq", int'(irq), 0);

    // power-down area 1 with settle 4
    wr('h0C, 'hFF);
    wr('h44, 'h2);
    rd('h00, v); chk("R2 ready low while busy", v, 0);
    rd('h48, v); chk("R11 shutoff in progress", v, 'h2);
    rd('h50, v); chk("R11 resume idle", v, 0);
    wait_idle(n);
    chk("R4 busy window settle=4", n, 4);
    rd('h40, v); chk("R3 area1 off", v, 'h2);
    rd('h04, v); chk("R8 flag bit1", v, 'h2);
    chk("R10 irq raised", int'(irq), 1);

    // mask and clear
    wr('h10, 'h02);
    chk("R10 irq masked", int'(irq), 0);
    rd('h04, v); chk("R10 flag kept under mask", v, 'h2);
    wr('h04, 'h0);
    rd('h04, v); chk("R9 status write ignored", v, 'h2);
    wr('h08, 'h2);
    rd('h04, v); chk("R9 clear by one", v, 0);
    wr('h10, 'h00);

    // busy rejection with a long settle
    wr('h14, 10);
    wr('h4C, 'h2);
    rd('h50, v); chk("R11 resume in progress", v, 'h2);
    wr('h6C, 'h1);
    rd('h74, v); chk("R5 error on busy", v, 'h1);
    wait_idle(n);
    rd('h60, v); chk("R5 group1 untouched", v, 'hF);
    rd('h40, v); chk("R3 area1 on again", v, 0);
    rd('h48, v); chk("R11 idle shutoff status", v, 0);

    // retry accepted
    wr('h6C, 'h1);
    rd('h74, v); chk("R6 error cleared", v, 0);
    wait_idle(n);
    chk("R4 busy window settle=10", n, 10);
    rd('h60, v); chk("R3 area4 on", v, 'hE);
    rd('h04, v); chk("R8 flag bit4", v, 'h12);
    wr('h08, 'hFF);

    // malformed commands
    wr('h44, 'h3);
    rd('h00, v); chk("R7 two bits ignored", v, 3);
    wr('h64, 'h10);
    rd('h00, v); chk("R7 out of range ignored", v, 3);
    rd('h74, v); chk("R7 no error", v, 0);
    rd('h60, v); chk("R7 power unchanged", v, 'hE);

    // completion with enable cleared
    wr('h0C, 'h00);
    wr('h14, 0);
    wr('h44, 'h1);
    wait_idle(n);
    chk("R4 zero settle acts as one", n, 1);
    rd('h40, v); chk("R3 area0 off", v, 'h1);
    rd('h04, v); chk("R8 no flag when disabled", v, 0);
    chk("R10 irq low", int'(irq), 0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule